// File: doc/BRIEF.md
# DMA Interrupt Status and Enable Register

This block holds the event flags and the interrupt enables of a ten-channel DMA controller in a single 32-bit word. The low half collects events: each channel sets its own flag when it finishes or faults, and a separate flag records a failed address decode on the bus. The high half holds one enable bit for each flag position. Hardware raises flags through per-channel set strobes and a bus-error strobe. The CPU reads the whole word and changes it through a simple address/data write port.

A CPU write works differently in each half. In the low half, a 1 acknowledges the matching flag and clears it. In the high half, a 1 flips the matching enable. A 0 in either half leaves that bit as it is. The register answers at its own address and also at a second address 0x100 higher, and a write there has the same effect. An interrupt line follows the AND of the channel flags and their enables, one clock behind the register.

Top module: `dma_irq_status`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `rd_data` is 0 and `irq` is 0.
- R2: A 1 on `ch_done[n]` (n = 0..9) sets flag bit n of `rd_data` at the next clock edge.
- R3: A 1 on `bus_err` sets flag bit 15 of `rd_data` at the next clock edge.
- R4: A write that hits the register clears every flag bit in [15:0] whose data bit is 1. Flag bits whose data bit is 0 keep their value.
- R5: A write that hits the register inverts every enable bit in [31:16] whose data bit is 1. Enable bits whose data bit is 0 keep their value. All 16 enable bits are stored and can be read back.
- R6: A write to address `REG_ADDR + 0x100` (default 0x110) has the same effect as a write to `REG_ADDR` (default 0x010).
- R7: A write to any other address changes nothing in `rd_data`.
- R8: When a flag is set by hardware and cleared by a write in the same cycle, the flag ends up set.
- R9: `irq` is registered. It is 1 in the cycle after a cycle in which (flags[9:0] AND enables[25:16]) is nonzero, and 0 otherwise. The bus-error flag and enable bit 31 do not drive `irq`.
- R10: Flag bits 10 to 14 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 12 | CPU write address |
| wr_data | input | 32 | CPU write data |
| ch_done | input | 10 | Per-channel event strobes |
| bus_err | input | 1 | Bus-error event strobe |
| rd_data | output | 32 | Current register value: enables [31:16], flags [15:0] |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench writes 1s to both halves in the same write. A design that cleared the enables, or flipped the flags, would show a wrong read-back at once. It sets and clears the same flag in one cycle, and a design that let the clear win would drop the event. It toggles an enable twice to confirm a true XOR rather than a set. It repeats writes at the alias address and at a nearby address, to catch a decoder that ignores the alias or matches too widely. It checks `irq` one cycle after each change, and with only the bus-error flag and its enable active, so that an unregistered interrupt or one driven by the bus error would be reported.

// File: rtl/dma_irq_status_pkg.sv
package dma_irq_status_pkg;

    localparam int HALF_W    = 16;
    localparam int NUM_CH    = 10;
    localparam int BERR_POS  = 15;
    localparam int ADDR_W    = 12;
    localparam logic [ADDR_W-1:0] REG_ADDR  = 12'h010;
    localparam logic [ADDR_W-1:0] ALIAS_OFS = 12'h100;

    typedef logic [HALF_W-1:0] half_t;

    typedef struct packed {
        logic  hit;
        half_t clr;
        half_t tog;
    } wr_cmd_t;

    // Flag positions that physically exist: channel bits plus bus-error bit.
    function automatic half_t impl_mask(input int nch, input int berr);
        half_t m;
        m = '0;
        for (int i = 0; i < HALF_W; i++) begin
            if (i < nch || i == berr) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dma_irq_flag_bank.sv
module dma_irq_flag_bank
    import dma_irq_status_pkg::*;
#(
    parameter half_t IMPL = '1
) (
    input  logic  clk,
    input  logic  rst,
    input  half_t set_i,
    input  half_t clr_i,
    output half_t flags_o
);

    for (genvar i = 0; i < HALF_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)             q <= 1'b0;
                else if (set_i[i])   q <= 1'b1;
                else if (clr_i[i])   q <= 1'b0;
            end
            assign flags_o[i] = q;

            // R8
            set_wins_chk: assert property (@(posedge clk) disable iff (rst)
                set_i[i] |=> flags_o[i]);
            // R4
            clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
                (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
            // R4
            flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!clr_i[i] && !set_i[i]) |=> $stable(flags_o[i]));
        end else begin : g_none
            assign flags_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/dma_irq_mask_bank.sv
module dma_irq_mask_bank
    import dma_irq_status_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  half_t tog_i,
    output half_t mask_o
);

    half_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_q ^ tog_i;
    end

    assign mask_o = mask_q;

    for (genvar i = 0; i < HALF_W; i++) begin : g_chk
        // R5
        mask_flip_chk: assert property (@(posedge clk) disable iff (rst)
            tog_i[i] |=> (mask_o[i] != $past(mask_o[i])));
        // R5
        mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
            !tog_i[i] |=> $stable(mask_o[i]));
    end

endmodule

// File: rtl/dma_irq_req_gen.sv
module dma_irq_req_gen
    import dma_irq_status_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic  clk,
    input  logic  rst,
    input  half_t flags_i,
    input  half_t mask_i,
    output logic  irq_o
);

    logic pend;
    assign pend = |(flags_i[NCH-1:0] & mask_i[NCH-1:0]);

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= pend;
    end

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_status_pkg::*;
#(
    parameter int                NCH   = NUM_CH,
    parameter int                AW    = ADDR_W,
    parameter logic [AW-1:0]     BASE  = REG_ADDR,
    parameter logic [AW-1:0]     ALIAS = ALIAS_OFS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [NCH-1:0]    ch_done,
    input  logic              bus_err,
    output logic [31:0]       rd_data,
    output logic              irq
);

    localparam half_t          IMPL       = impl_mask(NCH, BERR_POS);
    localparam logic [AW-1:0]  ALIAS_ADDR = BASE + ALIAS;

    wr_cmd_t cmd;
    half_t   set_vec;
    half_t   flags;
    half_t   mask;

    always_comb begin
        cmd.hit = wr_en && ((wr_addr == BASE) || (wr_addr == ALIAS_ADDR));
        cmd.clr = cmd.hit ? wr_data[HALF_W-1:0]      : '0;
        cmd.tog = cmd.hit ? wr_data[2*HALF_W-1:HALF_W] : '0;
    end

    for (genvar i = 0; i < HALF_W; i++) begin : g_set
        if (i < NCH) begin : g_ch
            assign set_vec[i] = ch_done[i];
        end else if (i == BERR_POS) begin : g_be
            assign set_vec[i] = bus_err;
        end else begin : g_zero
            assign set_vec[i] = 1'b0;
        end
    end

    dma_irq_flag_bank #(.IMPL(IMPL)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_vec),
        .clr_i   (cmd.clr),
        .flags_o (flags)
    );

    dma_irq_mask_bank u_mask (
        .clk    (clk),
        .rst    (rst),
        .tog_i  (cmd.tog),
        .mask_o (mask)
    );

    dma_irq_req_gen #(.NCH(NCH)) u_req (
        .clk     (clk),
        .rst     (rst),
        .flags_i (flags),
        .mask_i  (mask),
        .irq_o   (irq)
    );

    assign rd_data = {mask, flags};

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (|(rd_data[NCH-1:0] & rd_data[HALF_W+NCH-1:HALF_W])) |=> irq);
    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(rd_data[NCH-1:0] & rd_data[HALF_W+NCH-1:HALF_W])) |=> !irq);
    // R7
    miss_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != BASE && wr_addr != ALIAS_ADDR && ch_done == '0 && !bus_err)
        |=> $stable(rd_data));
    // R10
    gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[BERR_POS-1:NCH] == '0);
    // R3
    berr_set_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> rd_data[BERR_POS]);

endmodule

// File: tb/sim_dma_irq_status.sv
module sim_dma_irq_status;
    import dma_irq_status_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [9:0]  ch_done = '0;
    logic        bus_err = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    always #10 clk = ~clk;

    dma_irq_status u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ch_done(ch_done), .bus_err(bus_err),
        .rd_data(rd_data), .irq(irq)
    );

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] m_flag = '0;
    logic [15:0] m_mask = '0;

    // Monitor: compares after each rising edge.
    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (rd_data !== e.rd || irq !== e.irq) begin
                n_bad++;
                $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                         e.tag, rd_data, irq, e.rd, e.irq);
            end
        end
    end

    // Driver: applies one cycle of stimulus and pushes the model's result.
    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                        input logic [9:0] ch, input logic be, input string tag);
        exp_t        e;
        logic        hit;
        logic [15:0] setv;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; ch_done = ch; bus_err = be;
        e.irq = |(m_flag[9:0] & m_mask[9:0]);
        hit   = we && (a == 12'h010 || a == 12'h110);
        setv  = {be, 5'b0, ch};
        if (hit) begin
            m_flag = m_flag & ~d[15:0];
            m_mask = m_mask ^ d[31:16];
        end
        m_flag = m_flag | setv;
        e.rd  = {m_mask, m_flag};
        e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        if (rd_data !== 32'h0 || irq !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: rd_data=%h irq=%b expected 0 0", rd_data, irq);
        end
        n_cmp++;
        rst = 1'b0;
        step(0, 12'h000, 0, 10'h000, 0, "R1");
        step(0, 12'h000, 0, 10'h008, 0, "R2");
        step(0, 12'h000, 0, 10'h000, 0, "R9 no enable");
        step(1, 12'h010, 32'h0008_0000, 10'h000, 0, "R5 enable ch3");
        step(0, 12'h000, 0, 10'h000, 0, "R9 irq rises");
        step(0, 12'h000, 0, 10'h000, 0, "R9 irq held");
        step(0, 12'h000, 0, 10'h000, 1, "R3");
        step(1, 12'h010, 32'h8000_0008, 10'h000, 0, "R4 clear ch3 and R5 enable berr");
        step(0, 12'h000, 0, 10'h000, 0, "R9 irq falls, berr not a source");
        step(0, 12'h000, 0, 10'h000, 0, "R9 berr only");
        step(1, 12'h110, 32'h0001_8000, 10'h201, 0, "R6 alias clear and toggle");
        step(1, 12'h014, 32'hFFFF_FFFF, 10'h000, 0, "R7 wrong address");
        step(1, 12'h100, 32'hFFFF_FFFF, 10'h000, 0, "R7 offset only");
        step(1, 12'h010, 32'h0000_0200, 10'h200, 0, "R8 set beats clear");
        step(1, 12'h010, 32'h0200_0000, 10'h000, 0, "R5 toggle ch9 on");
        step(1, 12'h010, 32'h0200_0000, 10'h000, 0, "R5 toggle ch9 off");
        step(1, 12'h010, 32'h0000_0001, 10'h000, 0, "R4 clear ch0 keep ch9");
        step(0, 12'h000, 0, 10'h3FF, 1, "R2 all channels R10");
        step(1, 12'h110, 32'hFFFF_0000, 10'h000, 0, "R5 toggle all");
        step(0, 12'h000, 0, 10'h000, 0, "R9 all");
        step(1, 12'h010, 32'h0000_7C00, 10'h000, 0, "R10 gap bits");
        step(1, 12'h010, 32'h0000_FFFF, 10'h000, 0, "R4 clear all");
        step(0, 12'h000, 0, 10'h000, 0, "R9 idle after clear");
        step(0, 12'h000, 0, 10'h000, 0, "R9 settle");
        @(negedge clk);
        wr_en = 0; ch_done = '0; bus_err = 0;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule